// File: doc/BRIEF.md
# Time-Slot Test Frame Packer

This block sits on the tester side of a shared test bus and merges several per-core serial test streams onto one bus wire. The bus runs in repeating frames of `SLOT_COUNT` bit slots, and each clock carries one slot. Each core has a slot mask. A set bit in the mask gives that core the matching slot in every frame. A core with several set bits receives that many of its own bits per frame. The bits do not have to sit in adjacent slots.

Each core stream offers bits through a valid/ready handshake. The packer raises a core's ready only while the current slot belongs to that core. The accepted bit goes onto the bus on the next clock. Some slots have no bit to send: the slot has no owner, or its owner has nothing valid. Those slots carry a programmable fill value. A frame-start strobe marks slot 0 so that receivers can lock onto the frame. Masks and the fill value are written one core at a time through a configuration port. That port refuses any write that would give one slot to two cores.

Top module: `tsp_frame_packer`

## Requirements
- R1: While reset is held and right after it is released, `bus_bit`, `bus_sof`, `cfg_err` and every `in_ready` are 0. Reset clears all masks to empty and sets the fill value to 0.
- R2: Bit p of a core's mask (bit 0 = slot 0) gives slot p to that core. `in_ready[c]` is high in exactly those cycles in which the current slot is set in core c's mask, and at most one ready is high in any cycle.
- R3: A core's bits leave in increasing slot order within a frame and continue in the next frame. None is dropped or repeated. If a core's stream is valid from slot 0 onward, D bits with k mask ones are all accepted within ceil(D/k) frames. Example with 4 slots and masks 0001, 1010, 0100 (bit 0 first on the wire): the streams 11, 00 and none produce the frames 1,0,F,0 and then 1,F,F,F, where F is the fill value.
- R4: A bit accepted in slot s appears on `bus_bit` exactly one clock later.
- R5: A configuration write (`cfg_we`) to core `cfg_core` is accepted when `cfg_core` < `NUM_CORES` and `cfg_mask` shares no set bit with the mask of any other core. The core's own previous mask is not counted. An accepted write replaces that core's mask and the fill value, and clears `cfg_err`. A rejected write changes no mask and no fill value, and sets `cfg_err`. Either result shows from the next clock.
- R6: When a slot has no handshake, because the slot has no owner or its owner is not valid, `bus_bit` one clock later equals the fill value from the most recent accepted write.
- R7: The slot counter starts at 0 after reset and advances by one every clock, wrapping after `SLOT_COUNT` slots. `bus_sof` is high together with the bus bit of slot 0 and low for every other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core | input | CORE_IDX_W | Core whose mask is written |
| cfg_mask | input | SLOT_COUNT | New slot mask, bit p = slot p |
| cfg_fill | input | 1 | Fill value stored with an accepted write |
| cfg_err | output | 1 | High after a rejected write, cleared by an accepted one |
| in_valid | input | NUM_CORES | Per-core stream bit valid |
| in_data | input | NUM_CORES | Per-core stream bit |
| in_ready | output | NUM_CORES | Per-core accept, high only in owned slots |
| bus_bit | output | 1 | Shared test bus bit |
| bus_sof | output | 1 | High with the bit of slot 0 |

## Verification
Suppose the slot counter slips or a mask is written into the wrong row. Then a ready pulse shows up in a slot the core does not own, on the very cycle of the fault. The bus bit one clock later also carries the wrong core's data or the fill value. Suppose a rejected write were stored anyway. The ready pattern would change on the next clock, and the cycle-by-cycle ready comparison catches it. A lost or repeated stream bit shows two ways: a mismatch on the bus one clock after the handshake, and a wrong count of frames by the end of the run. So every internal error of this kind reaches the ports within one frame.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    // Outcome of a configuration write in a given cycle
    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_TAKE = 2'd1,
        CFG_DENY = 2'd2
    } cfg_verdict_e;

    // Index width that stays at least one bit for a single core
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsp_slot_counter.sv
module tsp_slot_counter #(
    parameter int unsigned SLOT_COUNT = 16,
    parameter int unsigned SLOT_W     = $clog2(SLOT_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              first_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_COUNT - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.slot == LAST_SLOT) begin
            cnt_d.slot = '0;
        end else begin
            cnt_d.slot = cnt_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign slot_o  = cnt_q.slot;
    assign first_o = (cnt_q.slot == '0);

endmodule

// File: rtl/tsp_mask_table.sv
module tsp_mask_table
    import tsp_pkg::*;
#(
    parameter int unsigned NUM_CORES  = 4,
    parameter int unsigned SLOT_COUNT = 16,
    parameter int unsigned CORE_IDX_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [CORE_IDX_W-1:0]                wr_core,
    input  logic [SLOT_COUNT-1:0]                wr_mask,
    input  logic                                 wr_fill,
    output logic [NUM_CORES-1:0][SLOT_COUNT-1:0] masks_o,
    output logic                                 fill_o,
    output logic                                 err_o
);

    typedef struct packed {
        logic [NUM_CORES-1:0][SLOT_COUNT-1:0] masks;
        logic                                 fill;
        logic                                 err;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [NUM_CORES-1:0] clash;
    logic                 in_range;
    cfg_verdict_e         verdict;

    // A slot collision with any core other than the one being rewritten
    for (genvar j = 0; j < NUM_CORES; j++) begin : g_clash
        assign clash[j] = (CORE_IDX_W'(j) != wr_core) && (|(tbl_q.masks[j] & wr_mask));
    end

    assign in_range = (32'(wr_core) < NUM_CORES);

    always_comb begin
        if (!wr_en) begin
            verdict = CFG_IDLE;
        end else if (in_range && !(|clash)) begin
            verdict = CFG_TAKE;
        end else begin
            verdict = CFG_DENY;
        end
    end

    always_comb begin
        tbl_d = tbl_q;
        unique case (verdict)
            CFG_TAKE: begin
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (CORE_IDX_W'(c) == wr_core) begin
                        tbl_d.masks[c] = wr_mask;
                    end
                end
                tbl_d.fill = wr_fill;
                tbl_d.err  = 1'b0;
            end
            CFG_DENY: begin
                tbl_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign masks_o = tbl_q.masks;
    assign fill_o  = tbl_q.fill;
    assign err_o   = tbl_q.err;

endmodule

// File: rtl/tsp_slot_select.sv
module tsp_slot_select #(
    parameter int unsigned NUM_CORES  = 4,
    parameter int unsigned SLOT_COUNT = 16,
    parameter int unsigned SLOT_W     = $clog2(SLOT_COUNT)
) (
    input  logic [NUM_CORES-1:0][SLOT_COUNT-1:0] masks_i,
    input  logic [SLOT_W-1:0]                    slot_i,
    input  logic [NUM_CORES-1:0]                 valid_i,
    input  logic [NUM_CORES-1:0]                 data_i,
    input  logic                                 fill_i,
    output logic [NUM_CORES-1:0]                 ready_o,
    output logic                                 bit_o
);

    logic [NUM_CORES-1:0] owns;
    logic [NUM_CORES-1:0] take;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_own
        assign owns[c] = masks_i[c][slot_i];
    end

    assign ready_o = owns;
    assign take    = owns & valid_i;

    always_comb begin
        if (|take) begin
            bit_o = |(take & data_i);
        end else begin
            bit_o = fill_i;
        end
    end

endmodule

// File: rtl/tsp_frame_packer.sv
module tsp_frame_packer
    import tsp_pkg::*;
#(
    parameter  int unsigned NUM_CORES  = 4,
    parameter  int unsigned SLOT_COUNT = 16,
    localparam int unsigned CORE_IDX_W = idx_width(NUM_CORES),
    localparam int unsigned SLOT_W     = $clog2(SLOT_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CORE_IDX_W-1:0] cfg_core,
    input  logic [SLOT_COUNT-1:0] cfg_mask,
    input  logic                  cfg_fill,
    output logic                  cfg_err,
    input  logic [NUM_CORES-1:0]  in_valid,
    input  logic [NUM_CORES-1:0]  in_data,
    output logic [NUM_CORES-1:0]  in_ready,
    output logic                  bus_bit,
    output logic                  bus_sof
);

    typedef struct packed {
        logic bit_v;
        logic sof;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_CORES-1:0][SLOT_COUNT-1:0] masks_w;
    logic                                 fill_w;
    logic [SLOT_W-1:0]                    slot_w;
    logic                                 first_w;
    logic                                 sel_bit_w;

    tsp_slot_counter #(
        .SLOT_COUNT(SLOT_COUNT),
        .SLOT_W    (SLOT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot_w),
        .first_o(first_w)
    );

    tsp_mask_table #(
        .NUM_CORES (NUM_CORES),
        .SLOT_COUNT(SLOT_COUNT),
        .CORE_IDX_W(CORE_IDX_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_core(cfg_core),
        .wr_mask(cfg_mask),
        .wr_fill(cfg_fill),
        .masks_o(masks_w),
        .fill_o (fill_w),
        .err_o  (cfg_err)
    );

    tsp_slot_select #(
        .NUM_CORES (NUM_CORES),
        .SLOT_COUNT(SLOT_COUNT),
        .SLOT_W    (SLOT_W)
    ) u_select (
        .masks_i(masks_w),
        .slot_i (slot_w),
        .valid_i(in_valid),
        .data_i (in_data),
        .fill_i (fill_w),
        .ready_o(in_ready),
        .bit_o  (sel_bit_w)
    );

    always_comb begin
        out_d       = out_q;
        out_d.bit_v = sel_bit_w;
        out_d.sof   = first_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_bit = out_q.bit_v;
    assign bus_sof = out_q.sof;

endmodule

// File: rtl/tsp_frame_packer_chk.sv
module tsp_frame_packer_chk #(
    parameter int unsigned NUM_CORES  = 4,
    parameter int unsigned SLOT_COUNT = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic                 cfg_err,
    input logic [NUM_CORES-1:0] in_valid,
    input logic [NUM_CORES-1:0] in_data,
    input logic [NUM_CORES-1:0] in_ready,
    input logic                 bus_bit,
    input logic                 bus_sof,
    input logic                 fill
);

    localparam int unsigned CW = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;

    logic [CW-1:0] ref_cnt_q;
    logic          sof_exp_q;
    logic          hs_any;
    logic          hs_bit;

    assign hs_any = |(in_valid & in_ready);
    assign hs_bit = |(in_valid & in_ready & in_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            sof_exp_q <= 1'b0;
        end else begin
            sof_exp_q <= (ref_cnt_q == '0);
            ref_cnt_q <= (32'(ref_cnt_q) == SLOT_COUNT - 1) ? '0 : ref_cnt_q + 1'b1;
        end
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready)); // R2

    AST_PASS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        hs_any |=> (bus_bit == $past(hs_bit))); // R4

    AST_FILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_any |=> (bus_bit == $past(fill))); // R6

    AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sof == sof_exp_q); // R7

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_we)); // R5

endmodule

bind tsp_frame_packer tsp_frame_packer_chk #(
    .NUM_CORES (NUM_CORES),
    .SLOT_COUNT(SLOT_COUNT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_err (cfg_err),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .bus_bit (bus_bit),
    .bus_sof (bus_sof),
    .fill    (fill_w)
);

// File: tb/tsp_frame_packer_tb.sv
module tsp_frame_packer_tb;

    localparam int unsigned NC = 3;
    localparam int unsigned SC = 4;
    localparam int unsigned IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [IW-1:0] cfg_core;
    logic [SC-1:0] cfg_mask;
    logic          cfg_fill;
    logic          cfg_err;
    logic [NC-1:0] in_valid;
    logic [NC-1:0] in_data;
    logic [NC-1:0] in_ready;
    logic          bus_bit;
    logic          bus_sof;

    always #4 clk = ~clk;

    tsp_frame_packer #(.NUM_CORES(NC), .SLOT_COUNT(SC)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_core(cfg_core),
        .cfg_mask(cfg_mask),
        .cfg_fill(cfg_fill),
        .cfg_err (cfg_err),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_ready(in_ready),
        .bus_bit (bus_bit),
        .bus_sof (bus_sof)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [SC-1:0] bm [NC];
    logic          bfill;
    logic          exp_bit, exp_sof, exp_err, exp_took;
    int            s, frame_no, seed;
    int            dlen [NC];
    int            dptr [NC];
    int            last_frame [NC];
    int            len_req [NC];

    // Pending configuration command for the next cycle
    logic          c_we;
    int            c_core;
    logic [SC-1:0] c_mask;
    logic          c_fill;

    function automatic logic gen_bit(input int c, input int i, input int sd);
        if (sd < 0) return (c == 0);
        return (((i * 5 + c * 3 + sd) >> 1) & 1) == 1;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (slot %0d frame %0d)", tag, act, exp, s, frame_no);
        end
    endtask

    task automatic cycle();
        logic er;
        logic ok;
        for (int c = 0; c < NC; c++) begin
            in_valid[c] = (dptr[c] < dlen[c]);
            in_data[c]  = gen_bit(c, dptr[c], seed);
        end
        cfg_we   = c_we;
        cfg_core = IW'(c_core);
        cfg_mask = c_mask;
        cfg_fill = c_fill;
        #1;
        exp_bit  = bfill;
        exp_took = 1'b0;
        for (int c = 0; c < NC; c++) begin
            er = bm[c][s];
            chk(in_ready[c] === er, "R2 ready in owned slot only", int'(in_ready[c]), int'(er));
            if (er && in_valid[c]) begin
                exp_bit  = in_data[c];
                exp_took = 1'b1;
                dptr[c]++;
                last_frame[c] = frame_no;
            end
        end
        exp_sof = (s == 0);
        if (c_we) begin
            ok = (c_core < NC);
            for (int j = 0; j < NC; j++) begin
                if (j != c_core && (bm[j] & c_mask) != '0) ok = 1'b0;
            end
            if (ok) begin
                bm[c_core] = c_mask;
                bfill      = c_fill;
                exp_err    = 1'b0;
            end else begin
                exp_err = 1'b1;
            end
        end
        c_we = 1'b0;
        s = (s + 1) % SC;
        if (s == 0) frame_no++;
        @(negedge clk);
        if (exp_took) chk(bus_bit === exp_bit, "R4 accepted bit on bus", int'(bus_bit), int'(exp_bit));
        else          chk(bus_bit === exp_bit, "R6 fill on idle slot", int'(bus_bit), int'(exp_bit));
        chk(bus_sof === exp_sof, "R7 frame start", int'(bus_sof), int'(exp_sof));
        chk(cfg_err === exp_err, "R5 error flag", int'(cfg_err), int'(exp_err));
    endtask

    task automatic write_cfg(input int core, input logic [SC-1:0] mask, input logic fill);
        c_we   = 1'b1;
        c_core = core;
        c_mask = mask;
        c_fill = fill;
        cycle();
    endtask

    task automatic run_streams(input int frames);
        int start;
        int k;
        while (s != 0) cycle();
        start = frame_no;
        for (int c = 0; c < NC; c++) begin
            k       = $countones(bm[c]);
            dlen[c] = (k == 0) ? 0 : len_req[c];
            dptr[c] = 0;
        end
        repeat (frames * SC) cycle();
        for (int c = 0; c < NC; c++) begin
            k = $countones(bm[c]);
            chk(dptr[c] == dlen[c], "R3 all bits delivered", dptr[c], dlen[c]);
            if (dlen[c] > 0) begin
                chk(last_frame[c] - start == (dlen[c] + k - 1) / k - 1,
                    "R3 frames needed", last_frame[c] - start, (dlen[c] + k - 1) / k - 1);
            end
            dlen[c] = 0;
            dptr[c] = 0;
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        cfg_we   = 1'b0;
        cfg_core = '0;
        cfg_mask = '0;
        cfg_fill = 1'b0;
        in_valid = '0;
        in_data  = '0;
        c_we = 1'b0; c_core = 0; c_mask = '0; c_fill = 1'b0;
        bfill = 1'b0; exp_bit = 1'b0; exp_sof = 1'b0; exp_err = 1'b0; exp_took = 1'b0;
        s = 0; frame_no = 0; seed = 0;
        for (int c = 0; c < NC; c++) begin
            bm[c] = '0; dlen[c] = 0; dptr[c] = 0; last_frame[c] = 0; len_req[c] = 0;
        end
        repeat (3) @(negedge clk);
        chk(bus_bit === 1'b0, "R1 reset bus bit", int'(bus_bit), 0);
        chk(bus_sof === 1'b0, "R1 reset frame start", int'(bus_sof), 0);
        chk(cfg_err === 1'b0, "R1 reset error flag", int'(cfg_err), 0);
        chk(in_ready === '0, "R1 reset ready", int'(in_ready), 0);
        rst_n = 1'b1;

        // Empty masks after reset: no ready, fill 0 (R1)
        repeat (6) cycle();

        // Worked example from the requirements (R3)
        write_cfg(0, 4'b0001, 1'b0);
        write_cfg(1, 4'b1010, 1'b0);
        write_cfg(2, 4'b0100, 1'b0);
        // Collision with core 0, then an out-of-range core (R5)
        write_cfg(2, 4'b0011, 1'b1);
        repeat (2) cycle();
        write_cfg(3, 4'b0000, 1'b1);
        // Rewriting a core's own slots is allowed (R5)
        write_cfg(0, 4'b0001, 1'b0);
        seed = -1;
        len_req[0] = 2; len_req[1] = 2; len_req[2] = 0;
        run_streams(3);

        // Unowned slot driven with fill 1 (R6)
        write_cfg(2, 4'b0000, 1'b1);
        len_req[0] = 1; len_req[1] = 1; len_req[2] = 1;
        seed = 3;
        run_streams(2);

        // Sweep every ownership pattern of the 4 slots (R2, R3, R4, R6)
        for (int cfg = 0; cfg < 256; cfg++) begin
            logic [SC-1:0] m [NC];
            logic          f;
            f = logic'(cfg & 1) ^ logic'((cfg >> 7) & 1);
            for (int c = 0; c < NC; c++) m[c] = '0;
            for (int p = 0; p < SC; p++) begin
                if (((cfg >> (2 * p)) & 3) < NC) m[(cfg >> (2 * p)) & 3][p] = 1'b1;
            end
            for (int c = 0; c < NC; c++) write_cfg(c, '0, f);
            for (int c = 0; c < NC; c++) write_cfg(c, m[c], f);
            seed = cfg;
            for (int c = 0; c < NC; c++) len_req[c] = (cfg + c) % 5;
            run_streams(4);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule